// File: doc/BRIEF.md
# Vector 4:2 Carry-Save Compressor Row

This block is a row of 4:2 compressor cells of configurable width. It takes four operand words of equal weight, plus one lateral carry bit entering the least significant position, and reduces them to a sum word and a carry word. The carry word weighs twice the sum word. Each cell hands a lateral carry to the cell above it. That carry is formed only from the cell's own first three operand bits, so no carry ripples across the row and the delay does not depend on the width. The row is purely combinational. It is meant to be placed inside larger reduction trees or accumulators, which add their own pipeline registers and their own final carry-propagate adder.

Each cell is two chained 3:2 full adders. The first adder takes operand bits a, b and c. Its carry leaves as the lateral carry-out. Its sum goes to the second adder together with operand bit d and the lateral carry-in. A parameter selects a second, equivalent form of the cell, written as an XOR/multiplexer network. The bit-level results of the two forms are identical.

Top module: `csa42_row`

## Requirements
- R1: In every bit position i, sum_o[i] + 2*(carry_o[i] + k_i) equals the number of ones among in_a[i], in_b[i], in_c[i], in_d[i] and the lateral carry entering bit i. Here k_i is the lateral carry leaving bit i, and the lateral carry entering bit 0 is lat_cin.
- R2: sum_o + 2*carry_o + 2^WIDTH*lat_cout equals in_a + in_b + in_c + in_d + lat_cin, taken as unsigned integers without loss.
- R3: lat_cout does not change when only lat_cin changes.
- R4: A change on lat_cin alone flips sum_o[0] or carry_o[0] and leaves sum_o[WIDTH-1:1] and carry_o[WIDTH-1:1] unchanged.
- R5: The lateral carry leaving bit i is the majority of in_a[i], in_b[i] and in_c[i]. For the top bit this is lat_cout. in_d[i] does not enter this majority.
- R6: When all four operand bits of a bit are 1, that bit's carry and lateral carry-out are both 1, and its sum equals its lateral carry-in. With all operands set to all ones, sum_o is ones above bit 0 with sum_o[0] = lat_cin, carry_o is all ones, and lat_cout is 1.
- R7: When a bit's lateral carry-in is 0 and two or three of its operand bits are 1, exactly one of its carry and its lateral carry-out is 1.
- R8: CELL_STYLE 0 (two full adders) and CELL_STYLE 1 (XOR/multiplexer form) produce identical outputs for every input.
- R9: Elaboration stops with an error when WIDTH is below 1 or CELL_STYLE is neither 0 nor 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | WIDTH | Operand word A; enters the first adder of each cell |
| in_b | input | WIDTH | Operand word B; enters the first adder of each cell |
| in_c | input | WIDTH | Operand word C; enters the first adder of each cell |
| in_d | input | WIDTH | Operand word D; enters the second adder of each cell |
| lat_cin | input | 1 | Lateral carry into bit 0 |
| sum_o | output | WIDTH | Sum word, weight 1 per position |
| carry_o | output | WIDTH | Carry word, weight 2 per position |
| lat_cout | output | 1 | Lateral carry leaving the top bit, weight 2^WIDTH |

## Verification
In any one evaluation, a cell can receive a lateral carry from below at the same time as it generates a lateral carry of its own. This happens whenever the lower cell sees two or more ones on a, b and c while the upper cell also sees two or more. An exhaustive sweep of a 4-bit row over all operand and carry-in values produces every such overlap, including the saturated case where all operands are one. Each result is judged by the word identity, by the majority rule for each bit's lateral carry, and by a paired comparison at both values of lat_cin, which shows that only bit 0 responds to lat_cin.

// File: rtl/csa42_pkg.sv
package csa42_pkg;

   localparam int STYLE_FA_PAIR = 0;
   localparam int STYLE_XOR_MUX = 1;

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

endpackage

// File: rtl/fa32_cell.sv
module fa32_cell (
   input  logic x_i,
   input  logic y_i,
   input  logic z_i,
   output logic s_o,
   output logic c_o
);
   import csa42_pkg::*;

   always_comb begin
      s_o = x_i ^ y_i ^ z_i;
      c_o = maj3(x_i, y_i, z_i);
   end
endmodule

// File: rtl/cmp42_cell.sv
module cmp42_cell #(
   parameter int CELL_STYLE = 0
) (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   input  logic d_i,
   input  logic lin_i,
   output logic s_o,
   output logic cy_o,
   output logic lout_o
);
   import csa42_pkg::*;

   generate
      if (CELL_STYLE == STYLE_FA_PAIR) begin : g_fa_pair
         logic mid_s;
         fa32_cell u_upper (
            .x_i (a_i),
            .y_i (b_i),
            .z_i (c_i),
            .s_o (mid_s),
            .c_o (lout_o)
         );
         fa32_cell u_lower (
            .x_i (mid_s),
            .y_i (d_i),
            .z_i (lin_i),
            .s_o (s_o),
            .c_o (cy_o)
         );
      end else begin : g_xor_mux
         logic par4;
         always_comb begin
            lout_o = maj3(a_i, b_i, c_i);
            par4   = a_i ^ b_i ^ c_i ^ d_i;
            s_o    = par4 ^ lin_i;
            cy_o   = par4 ? lin_i : d_i;
         end
      end
   endgenerate
endmodule

// File: rtl/csa42_row.sv
module csa42_row #(
   parameter int WIDTH      = 16,
   parameter int CELL_STYLE = 0
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic [WIDTH-1:0] in_c,
   input  logic [WIDTH-1:0] in_d,
   input  logic             lat_cin,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] carry_o,
   output logic             lat_cout
);
   import csa42_pkg::*;

   localparam int NLINK = WIDTH + 1;

   // R9: reject unusable configurations at elaboration
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("csa42_row: WIDTH must be at least 1");
      end
      if (CELL_STYLE != STYLE_FA_PAIR && CELL_STYLE != STYLE_XOR_MUX) begin : g_bad_style
         $error("csa42_row: CELL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [NLINK-1:0] lat_link;

   assign lat_link[0] = lat_cin;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         cmp42_cell #(.CELL_STYLE(CELL_STYLE)) u_cell (
            .a_i    (in_a[i]),
            .b_i    (in_b[i]),
            .c_i    (in_c[i]),
            .d_i    (in_d[i]),
            .lin_i  (lat_link[i]),
            .s_o    (sum_o[i]),
            .cy_o   (carry_o[i]),
            .lout_o (lat_link[i+1])
         );
      end
   endgenerate

   assign lat_cout = lat_link[WIDTH];
endmodule

// File: rtl/csa42_row_chk.sv
module csa42_row_chk #(
   parameter int WIDTH = 16
) (
   input logic [WIDTH-1:0] in_a,
   input logic [WIDTH-1:0] in_b,
   input logic [WIDTH-1:0] in_c,
   input logic [WIDTH-1:0] in_d,
   input logic             lat_cin,
   input logic [WIDTH-1:0] sum_o,
   input logic [WIDTH-1:0] carry_o,
   input logic             lat_cout,
   input logic [WIDTH:0]   lat_link
);
   localparam int EW = WIDTH + 3;

   logic [EW-1:0] lhs_w, rhs_w;

   always_comb begin
      lhs_w = EW'(sum_o) + (EW'(carry_o) << 1) + (EW'(lat_cout) << WIDTH);
      rhs_w = EW'(in_a) + EW'(in_b) + EW'(in_c) + EW'(in_d) + EW'(lat_cin);
      // R2
      word_sum_chk: assert (lhs_w == rhs_w);
      // R3
      top_out_src_chk: assert (lat_cout == ((in_a[WIDTH-1] & in_b[WIDTH-1]) |
                                            (in_a[WIDTH-1] & in_c[WIDTH-1]) |
                                            (in_b[WIDTH-1] & in_c[WIDTH-1])));
      // R4
      bottom_in_chk: assert (lat_link[0] == lat_cin);
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bitchk
      logic [2:0] left_n, right_n;
      always_comb begin
         left_n  = 3'(sum_o[i]) + 3'(2 * (32'(carry_o[i]) + 32'(lat_link[i+1])));
         right_n = 3'(in_a[i]) + 3'(in_b[i]) + 3'(in_c[i]) + 3'(in_d[i]) + 3'(lat_link[i]);
         // R1
         bit_count_chk: assert (left_n == right_n);
         // R6
         all_ones_chk: assert (!(in_a[i] & in_b[i] & in_c[i] & in_d[i]) ||
                               (carry_o[i] && lat_link[i+1] && sum_o[i] == lat_link[i]));
         // R7
         one_of_two_chk: assert (lat_link[i] ||
                                 !((32'(in_a[i]) + 32'(in_b[i]) + 32'(in_c[i]) + 32'(in_d[i])) inside {2, 3}) ||
                                 (carry_o[i] ^ lat_link[i+1]));
      end
   end
endmodule

bind csa42_row csa42_row_chk #(.WIDTH(WIDTH)) u_chk (
   .in_a     (in_a),
   .in_b     (in_b),
   .in_c     (in_c),
   .in_d     (in_d),
   .lat_cin  (lat_cin),
   .sum_o    (sum_o),
   .carry_o  (carry_o),
   .lat_cout (lat_cout),
   .lat_link (lat_link)
);

// File: tb/csa42_row_tb_top.sv
module csa42_row_tb_top;
   localparam int W = 4;
   localparam int WATCHDOG = 190000;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [W-1:0] a, b, c, d;
   logic         cin;
   logic [W-1:0] s0, cy0, s1, cy1;
   logic         co0, co1;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   csa42_row #(.WIDTH(W), .CELL_STYLE(0)) dut_i (
      .in_a(a), .in_b(b), .in_c(c), .in_d(d), .lat_cin(cin),
      .sum_o(s0), .carry_o(cy0), .lat_cout(co0)
   );

   csa42_row #(.WIDTH(W), .CELL_STYLE(1)) dut_alt_i (
      .in_a(a), .in_b(b), .in_c(c), .in_d(d), .lat_cin(cin),
      .sum_o(s1), .carry_o(cy1), .lat_cout(co1)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d (a=%0h b=%0h c=%0h d=%0h cin=%0b)",
                  req, act, exp, a, b, c, d, cin);
      end
   endtask

   function automatic int mj(input int x, input int y, input int z);
      return (x + y + z) >= 2 ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] keep_s, keep_cy;
      logic         keep_co;
      a = '0; b = '0; c = '0; d = '0; cin = 1'b0;
      @(negedge clk);
      // R2: all-zero input gives all-zero outputs
      check(s0 == 0 && cy0 == 0 && co0 == 0, "R2 zero", int'(s0) + int'(cy0) + int'(co0), 0);

      for (int v = 0; v < (1 << (4 * W)); v++) begin
         for (int ci = 0; ci < 2; ci++) begin
            int expect_total, got_total, cnt0, k0, k_top;
            a = v[W-1:0]; b = v[2*W-1:W]; c = v[3*W-1:2*W]; d = v[4*W-1:3*W];
            cin = ci[0];
            @(negedge clk);
            expect_total = int'(a) + int'(b) + int'(c) + int'(d) + ci;
            got_total    = int'(s0) + 2 * int'(cy0) + (int'(co0) << W);
            // R2
            check(got_total == expect_total, "R2", got_total, expect_total);
            // R5: top lateral carry is majority of a,b,c at the top bit
            k_top = mj(int'(a[W-1]), int'(b[W-1]), int'(c[W-1]));
            check(int'(co0) == k_top, "R5", int'(co0), k_top);
            // R1: bit 0 count, lateral out of bit 0 taken from R5
            k0   = mj(int'(a[0]), int'(b[0]), int'(c[0]));
            cnt0 = int'(a[0]) + int'(b[0]) + int'(c[0]) + int'(d[0]) + ci;
            check(int'(s0[0]) + 2 * (int'(cy0[0]) + k0) == cnt0, "R1",
                  int'(s0[0]) + 2 * (int'(cy0[0]) + k0), cnt0);
            // R7: bit 0 with lateral in 0 and two or three ones
            if (ci == 0 && (cnt0 == 2 || cnt0 == 3))
               check((int'(cy0[0]) + k0) == 1, "R7", int'(cy0[0]) + k0, 1);
            // R8
            check(s0 == s1 && cy0 == cy1 && co0 == co1, "R8",
                  int'({co1, cy1, s1}), int'({co0, cy0, s0}));
            if (ci == 0) begin
               keep_s = s0; keep_cy = cy0; keep_co = co0;
            end else begin
               // R3
               check(co0 == keep_co, "R3", int'(co0), int'(keep_co));
               // R4
               check(s0[W-1:1] == keep_s[W-1:1] && cy0[W-1:1] == keep_cy[W-1:1], "R4",
                     int'({s0[W-1:1], cy0[W-1:1]}), int'({keep_s[W-1:1], keep_cy[W-1:1]}));
               check((s0[0] != keep_s[0]) || (cy0[0] != keep_cy[0]), "R4 bit0",
                     int'({s0[0], cy0[0]}), int'({~keep_s[0], keep_cy[0]}));
            end
         end
      end

      // R6: saturated operands at both lateral carry-in values
      for (int ci = 0; ci < 2; ci++) begin
         a = '1; b = '1; c = '1; d = '1; cin = ci[0];
         @(negedge clk);
         check(s0 == {{(W-1){1'b1}}, cin}, "R6 sum", int'(s0), int'({{(W-1){1'b1}}, cin}));
         check(cy0 == '1 && co0 == 1'b1, "R6 carry", int'({co0, cy0}), (1 << (W + 1)) - 1);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule